// File: doc/BRIEF.md
# Serial Input Bit Delay Aligner

This block realigns one serial input stream of a time-division-multiplexed link against a shared master frame pulse. It runs on a clock at four times the bit rate, so each bit cell of the incoming stream spans four clock cycles. A local bit timer restarts on every frame pulse. Once per local bit it hands out one recovered bit with a one-cycle valid strobe. A frame-start strobe marks the first bit of the delayed frame. With a 32.768 Mbit/s stream the clock runs at 131.072 MHz, and the frame pulse comes from the 8.192 MHz frame clock domain.

Every stream has its own 5-bit delay field and a mode bit, so each stream can have its own frame boundary. With the mode bit low, the whole field is a delay in quarter-bit steps, from 0 up to 7 3/4 bits. With the mode bit high, the upper three bits are a delay in whole bits, and the lower two bits choose the point in the bit cell at which the data is taken. The field and the mode bit are captured only on a frame pulse, so a frame that is already under way is never disturbed. Internally the oversampled input runs down a 32-stage shift line. The active setting picks one tap of that line, and the tap is read once per local bit.

The frame pulse is high for one clock in the first quarter of bit 0 of a frame. Frames are at least nine bits long.

Top module: `serial_bit_aligner`

## Requirements
- R1: `bit_valid` is high for exactly one cycle in every four. It is high in cycle P+4m+4 for m = 0, 1, 2, …, where P is the cycle in which `frm_pulse` is high. It is never high before the first frame pulse.
- R2: With `pt_mode` = 0 and captured field value D (0..31, in quarter bits), the bit presented with the strobe in cycle P+4m+4 equals `ser_in` as it was in cycle P+4m+3−D.
- R3: With `pt_mode` = 1, field bits [4:2] give a whole-bit lag I (0..7). The bit presented in cycle P+4m+4 equals `ser_in` in cycle P+4(m−I)+j−1, where j/4 is the selected sampling location.
- R4: With `pt_mode` = 1, field bits [1:0] select the sampling location j/4 as follows: code 0 gives 3/4, code 1 gives 4/4, code 2 gives 1/4 and code 3 gives 2/4.
- R5: `frame_start` is high together with `bit_valid` only for m = floor(D/4) when `pt_mode` = 0, or m = I when `pt_mode` = 1. It is high exactly once per frame.
- R6: `dly_cfg` and `pt_mode` are captured only in a cycle with `frm_pulse` high. Values driven in other cycles have no effect on any output.
- R7: While `rst` is high, and after it falls until the first frame pulse, all outputs are 0. Reset clears the shift line, so input taken before reset reads as 0.
- R8: `rec_bit` holds its value in every cycle in which `bit_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, four cycles per bit |
| rst | input | 1 | Synchronous active-high reset |
| frm_pulse | input | 1 | Master frame pulse, one cycle wide |
| ser_in | input | 1 | Serial input data |
| dly_cfg | input | 5 | Delay field, read according to `pt_mode` |
| pt_mode | input | 1 | 0: quarter-bit delay; 1: whole-bit delay plus sampling point |
| rec_bit | output | 1 | Recovered bit, updated with each strobe |
| bit_valid | output | 1 | One-cycle strobe per local bit |
| frame_start | output | 1 | Strobe marking the first bit of the delayed frame |

## Verification
Every output is registered, so a result shows up one clock after the cycle in which the local bit timer reaches its fourth quarter. That cycle is four cycles per bit after the frame pulse. The bench keeps its own history of the input. At each drive step it works out what the next edge must produce: the input from the cycle that lies the captured delay behind the sampling cycle, together with the strobe and frame-start flags. It then compares all three outputs on the following falling edge. Some frames change the input every quarter bit, so that the choice of sampling location can be seen. Other frames drive random settings between frame pulses to show that those settings are ignored until the next frame pulse.

// File: rtl/sba_pkg.sv
package sba_pkg;

   // log2 of the oversampling ratio: four clocks per bit cell
   localparam int SBA_QTR_W = 2;

   typedef enum logic {
      SBA_MODE_FRAC  = 1'b0,
      SBA_MODE_POINT = 1'b1
   } sba_mode_e;

   // Quarter index (0 = first quarter) at which the selected location lies.
   // Code order is non-monotonic: 3/4, 4/4, 1/4, 2/4.
   function automatic logic [SBA_QTR_W-1:0] sba_sample_qtr(input logic [SBA_QTR_W-1:0] code);
      return code + 2'd2;
   endfunction

endpackage

// File: rtl/sba_cfg_latch.sv
module sba_cfg_latch
   import sba_pkg::*;
#(
   parameter int DLY_W = 5,
   localparam int LAG_W = DLY_W - SBA_QTR_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             frm_pulse,
   input  logic [DLY_W-1:0] dly_cfg,
   input  logic             pt_mode,
   output logic [DLY_W-1:0] tap_sel,
   output logic [LAG_W-1:0] bit_lag
);

   sba_mode_e                mode_e;
   logic [DLY_W-1:0]         tap_nxt;
   logic [SBA_QTR_W-1:0]     qtr_pos;

   assign mode_e  = sba_mode_e'(pt_mode);
   assign qtr_pos = sba_sample_qtr(dly_cfg[SBA_QTR_W-1:0]);

   // Tap distance in clocks. Sampling-point mode: whole bits times four
   // plus the distance from the chosen quarter to the end of the cell.
   always_comb begin
      unique case (mode_e)
         SBA_MODE_FRAC:  tap_nxt = dly_cfg;
         SBA_MODE_POINT: tap_nxt = {dly_cfg[DLY_W-1:SBA_QTR_W], 2'd3 - qtr_pos};
         default:        tap_nxt = dly_cfg;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst)            tap_sel <= '0;
      else if (frm_pulse) tap_sel <= tap_nxt;
   end

   assign bit_lag = tap_sel[DLY_W-1:SBA_QTR_W];

endmodule

// File: rtl/sba_bit_timer.sv
module sba_bit_timer
   import sba_pkg::*;
#(
   parameter int BCNT_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              frm_pulse,
   output logic              strobe,
   output logic [BCNT_W-1:0] cur_bit
);

   localparam logic [BCNT_W-1:0] BCNT_MAX = '1;

   logic [SBA_QTR_W-1:0] qtr;
   logic [SBA_QTR_W-1:0] cur_qtr;
   logic [BCNT_W-1:0]    bcnt;
   logic                 armed;

   assign cur_qtr = frm_pulse ? '0 : qtr;
   assign cur_bit = frm_pulse ? '0 : bcnt;
   assign strobe  = armed && (cur_qtr == '1);

   always_ff @(posedge clk) begin
      if (rst) begin
         qtr   <= '0;
         bcnt  <= '0;
         armed <= 1'b0;
      end else begin
         armed <= armed | frm_pulse;
         qtr   <= cur_qtr + 1'b1;
         if (frm_pulse)                      bcnt <= '0;
         else if (strobe && bcnt != BCNT_MAX) bcnt <= bcnt + 1'b1;
      end
   end

endmodule

// File: rtl/sba_tap_line.sv
module sba_tap_line #(
   parameter int IDX_W = 5,
   localparam int DEPTH = 1 << IDX_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             din,
   input  logic [IDX_W-1:0] sel,
   output logic             tap
);

   logic [DEPTH-1:1] stg;
   logic [DEPTH-1:0] line;

   assign line = {stg, din};

   for (genvar k = 1; k < DEPTH; k++) begin : g_stage
      always_ff @(posedge clk) begin
         if (rst) stg[k] <= 1'b0;
         else     stg[k] <= line[k-1];
      end
   end

   assign tap = line[sel];

endmodule

// File: rtl/serial_bit_aligner.sv
module serial_bit_aligner
   import sba_pkg::*;
#(
   parameter int DLY_W = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             frm_pulse,
   input  logic             ser_in,
   input  logic [DLY_W-1:0] dly_cfg,
   input  logic             pt_mode,
   output logic             rec_bit,
   output logic             bit_valid,
   output logic             frame_start
);

   localparam int LAG_W  = DLY_W - SBA_QTR_W;
   localparam int BCNT_W = LAG_W + 1;

   if (DLY_W < 3 || DLY_W > 8) begin : g_bad_width
      $error("serial_bit_aligner: DLY_W must lie in 3..8");
   end

   logic [DLY_W-1:0]  tap_sel;
   logic [LAG_W-1:0]  bit_lag;
   logic              strobe;
   logic [BCNT_W-1:0] cur_bit;
   logic              tap;

   sba_cfg_latch #(.DLY_W(DLY_W)) u_cfg (
      .clk(clk), .rst(rst), .frm_pulse(frm_pulse),
      .dly_cfg(dly_cfg), .pt_mode(pt_mode),
      .tap_sel(tap_sel), .bit_lag(bit_lag)
   );

   sba_bit_timer #(.BCNT_W(BCNT_W)) u_timer (
      .clk(clk), .rst(rst), .frm_pulse(frm_pulse),
      .strobe(strobe), .cur_bit(cur_bit)
   );

   sba_tap_line #(.IDX_W(DLY_W)) u_line (
      .clk(clk), .rst(rst), .din(ser_in), .sel(tap_sel), .tap(tap)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         rec_bit     <= 1'b0;
         bit_valid   <= 1'b0;
         frame_start <= 1'b0;
      end else begin
         bit_valid   <= strobe;
         frame_start <= strobe && (cur_bit == {1'b0, bit_lag});
         if (strobe) rec_bit <= tap;
      end
   end

endmodule

// File: rtl/sba_checker.sv
module sba_checker (
   input logic clk,
   input logic rst,
   input logic frm_pulse,
   input logic rec_bit,
   input logic bit_valid,
   input logic frame_start
);

   logic seen_fp;
   logic fs_seen;

   always_ff @(posedge clk) begin
      if (rst) begin
         seen_fp <= 1'b0;
         fs_seen <= 1'b0;
      end else begin
         seen_fp <= seen_fp | frm_pulse;
         if (frm_pulse)        fs_seen <= 1'b0;
         else if (frame_start) fs_seen <= 1'b1;
      end
   end

   a_r1_valid_gap: assert property (@(posedge clk) disable iff (rst)
      bit_valid |=> !bit_valid);

   a_r1_quiet_before_frame: assert property (@(posedge clk) disable iff (rst)
      !seen_fp |-> !bit_valid);

   a_r5_start_with_valid: assert property (@(posedge clk) disable iff (rst)
      frame_start |-> bit_valid);

   a_r5_single_start: assert property (@(posedge clk) disable iff (rst)
      frame_start |-> !fs_seen);

   a_r7_reset_clears: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!bit_valid && !frame_start && !rec_bit));

   a_r8_bit_held: assert property (@(posedge clk) disable iff (rst)
      (!bit_valid && !$past(rst)) |-> $stable(rec_bit));

endmodule

bind serial_bit_aligner sba_checker u_sba_checker (
   .clk(clk), .rst(rst), .frm_pulse(frm_pulse),
   .rec_bit(rec_bit), .bit_valid(bit_valid), .frame_start(frame_start)
);

// File: tb/serial_bit_aligner_bench.sv
`timescale 1ns/1ps
module serial_bit_aligner_bench;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       frm_pulse = 1'b0;
   logic       ser_in = 1'b0;
   logic [4:0] dly_cfg = '0;
   logic       pt_mode = 1'b0;
   logic       rec_bit, bit_valid, frame_start;

   always #4 clk = ~clk;

   serial_bit_aligner u_serial_bit_aligner (
      .clk(clk), .rst(rst), .frm_pulse(frm_pulse), .ser_in(ser_in),
      .dly_cfg(dly_cfg), .pt_mode(pt_mode),
      .rec_bit(rec_bit), .bit_valid(bit_valid), .frame_start(frame_start)
   );

   int    n_chk = 0;
   int    n_fail = 0;
   bit    done = 1'b0;

   // model state
   bit    hist [64];
   int    cyc = 64;
   int    tf = 0;
   bit    armed = 1'b0;
   int    act_d = 0;
   bit    act_mode = 1'b0;
   bit    exp_bit = 1'b0, exp_v = 1'b0, exp_fs = 1'b0;
   string bit_tag = "R8";
   string force_tag = "";

   function automatic int exp_delay(bit [4:0] f, bit m);
      int j;
      if (!m) return int'(f);
      case (f[1:0])
         2'd0: j = 3;
         2'd1: j = 4;
         2'd2: j = 1;
         default: j = 2;
      endcase
      return 4 * int'(f[4:2]) + 4 - j;
   endfunction

   task automatic check(string tag, bit got, bit expv, string what);
      n_chk++;
      if (got !== expv) begin
         n_fail++;
         $display("FAIL %s %s at cycle %0d: got %0b expected %0b", tag, what, cyc, got, expv);
      end
   endtask

   task automatic compare_all();
      check("R1", bit_valid, exp_v, "bit_valid");
      check("R5", frame_start, exp_fs, "frame_start");
      check(bit_tag, rec_bit, exp_bit, "rec_bit");
   endtask

   // drive one cycle (called at negedge), predict, then check after the edge
   task automatic step(bit fp, bit din, bit [4:0] dly, bit mode);
      bit strobe;
      frm_pulse = fp; ser_in = din; dly_cfg = dly; pt_mode = mode;
      hist[cyc % 64] = din;
      if (fp) tf = 0; else tf++;
      strobe = armed && !fp && (tf % 4 == 3);
      if (strobe) begin
         exp_bit = hist[(cyc - act_d) % 64];
         exp_v   = 1'b1;
         exp_fs  = (tf / 4) == (act_d / 4);
         bit_tag = (force_tag != "") ? force_tag : (act_mode ? "R3" : "R2");
      end else begin
         exp_v   = 1'b0;
         exp_fs  = 1'b0;
         bit_tag = "R8";
      end
      if (fp) begin
         act_d    = exp_delay(dly, mode);
         act_mode = mode;
         armed    = 1'b1;
      end
      cyc++;
      @(posedge clk);
      @(negedge clk);
      compare_all();
   endtask

   task automatic do_reset(int n);
      rst = 1'b1; frm_pulse = 1'b0; ser_in = 1'b0;
      foreach (hist[i]) hist[i] = 1'b0;
      armed = 1'b0; act_d = 0; act_mode = 1'b0;
      exp_bit = 1'b0; exp_v = 1'b0; exp_fs = 1'b0;
      for (int i = 0; i < n; i++) begin
         cyc++;
         @(posedge clk);
         @(negedge clk);
         check("R7", bit_valid, 1'b0, "bit_valid in reset");
         check("R7", frame_start, 1'b0, "frame_start in reset");
         check("R7", rec_bit, 1'b0, "rec_bit in reset");
      end
      rst = 1'b0;
   endtask

   // qrand: new data every quarter; junk: random settings between pulses
   task automatic run_frame(int nbits, bit [4:0] dly, bit mode, bit qrand, bit junk);
      bit b = 1'b0;
      for (int t = 0; t < 4 * nbits; t++) begin
         if (qrand || t % 4 == 0) b = 1'($urandom);
         if (t == 0)     step(1'b1, b, dly, mode);
         else if (junk)  step(1'b0, b, 5'($urandom), 1'($urandom));
         else            step(1'b0, b, dly, mode);
      end
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      @(negedge clk);
      do_reset(5);
      // R7: idle after reset with data toggling, no frame pulse yet
      force_tag = "R7";
      for (int i = 0; i < 12; i++) step(1'b0, 1'($urandom), 5'd9, 1'b1);
      force_tag = "";
      // R2: every quarter-bit delay, both data patterns
      for (int d = 0; d < 32; d++) run_frame(12, 5'(d), 1'b0, d[0], 1'b0);
      // R3 and R4: every whole-bit lag and phase code, quarter-rate data
      force_tag = "R4";
      for (int d = 0; d < 32; d++) run_frame(11, 5'(d), 1'b1, 1'b1, 1'b0);
      force_tag = "";
      for (int d = 0; d < 32; d += 5) run_frame(10, 5'(d), 1'b1, 1'b0, 1'b0);
      // R6: settings that change between pulses must be ignored
      force_tag = "R6";
      for (int i = 0; i < 8; i++) run_frame(10, 5'($urandom), 1'($urandom), 1'b1, 1'b1);
      force_tag = "";
      // directed extremes: longest lag in both modes
      run_frame(12, 5'd31, 1'b0, 1'b1, 1'b0);
      run_frame(12, 5'd31, 1'b1, 1'b1, 1'b0);
      run_frame(12, 5'd0,  1'b0, 1'b1, 1'b0);
      // R7: reset in mid-frame, then history must read as zero
      run_frame(5, 5'd20, 1'b0, 1'b1, 1'b0);
      do_reset(3);
      run_frame(12, 5'd31, 1'b0, 1'b0, 1'b0);
      // random mix
      for (int i = 0; i < 40; i++)
         run_frame(9 + int'($urandom % 8), 5'($urandom), 1'($urandom),
                   1'($urandom), 1'($urandom % 4 == 0));
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule